// File: doc/BRIEF.md
# Bidirectional Debug Mailbox Channel

This block moves 32-bit words between an external debug host and software running on a processor core. It holds two independent one-word mailboxes. The receive mailbox carries words from the host to the core. The transmit mailbox carries words from the core to the host. Each mailbox has a full flag. One status word shows both flags, and both ports can read it.

Each side has its own simple register port: an address, a read strobe, a write strobe, write data and read data. On the core port, address 0 is the status word and address 1 is the data word. A core read of address 1 empties the receive mailbox, and a core write of address 1 fills the transmit mailbox. On the host port, word index 34 is the status word, index 32 is the receive-data register (write only), and index 35 is the transmit-data register (read only).

Read data is combinational: it is valid in the same cycle as the read strobe, and it is zero when no read is decoded. Flag and data updates take effect on the next rising clock edge. An access made in the wrong state changes nothing.

Top module: `dbgMailbox`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both full flags and both data words, so both status words read zero afterwards.
- R2: The status word has the receive-full flag at bit 30 and the transmit-full flag at bit 29. All other bits read zero. It reads the same at core address 0 and at host index 34.
- R3: A host write to index 32 while receive-full is 0 stores the write data and sets receive-full, which status shows on the next cycle.
- R4: A host write to index 32 while receive-full is 1 is dropped: both the stored word and the flag stay unchanged.
- R5: A core read of address 1 while receive-full is 1 returns the stored word in the same cycle and clears receive-full at the next edge. A read in the very next cycle already sees the cleared flag.
- R6: A core read of address 1 while receive-full is 0 returns zero and changes no state.
- R7: A core write of address 1 while transmit-full is 0 stores the word and sets transmit-full.
- R8: A core write of address 1 while transmit-full is 1 is dropped: the stored word and the flag stay unchanged.
- R9: A host read of index 35 while transmit-full is 1 returns the stored word and clears transmit-full.
- R10: A host read of index 35 while transmit-full is 0 returns zero and leaves the flag unchanged.
- R11: When a mailbox is filled and emptied in the same cycle, both accesses are judged on the flag at the start of that cycle. If the flag is empty, the write takes effect (the flag ends set) and the read returns zero. If the flag is full, the read returns the old word and takes effect (the flag ends clear), and the write is dropped.
- R12: A host access to any other index returns zero and changes nothing. This includes reads of index 32 and writes to indices 34 and 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostAddr | input | 8 | Host word index |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, same cycle |
| coreAddr | input | 1 | Core register select (0 status, 1 data) |
| coreRd | input | 1 | Core read strobe |
| coreWr | input | 1 | Core write strobe |
| coreWdata | input | 32 | Core write data |
| coreRdata | output | 32 | Core read data, same cycle |

## Verification
The hardest case to reach is a collision: the host port and the core port access the same mailbox in the same cycle. This must be tested both with the mailbox empty and with it full, and each case gives a different winner. The stimulus first sets the flag to a known state with single accesses. It then drives the filling write and the emptying read together in one cycle. It checks the returned word in that cycle and the status in the next. A long run of random accesses on both ports, with addresses drawn from the decoded indices, then revisits these collisions. A behavioural model judges every cycle.

// File: rtl/dbgMbxPkg.sv
package dbgMbxPkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W      = 32;
  localparam int HOST_AW     = 8;
  localparam int RX_FULL_BIT = 30;
  localparam int TX_FULL_BIT = 29;
  localparam int HIDX_RXDATA = 32;
  localparam int HIDX_STATUS = 34;
  localparam int HIDX_TXDATA = 35;
  localparam logic CADDR_STATUS = 1'b0;
  localparam logic CADDR_DATA   = 1'b1;

  // Strobes from control to datapath, one per qualified action
  typedef struct packed {
    logic rxLoad;    // host fills receive mailbox
    logic rxTake;    // core empties receive mailbox
    logic txLoad;    // core fills transmit mailbox
    logic txTake;    // host empties transmit mailbox
    logic hostStat;  // host status read
    logic coreStat;  // core status read
  } mbxStrobe_t;
endpackage

// File: rtl/dbgMbxCtrl.sv
module dbgMbxCtrl
  import dbgMbxPkg::*;
#(
  parameter int HOST_AW = dbgMbxPkg::HOST_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic               coreAddr,
  input  logic               coreRd,
  input  logic               coreWr,
  output mbxStrobe_t         strobe,
  output logic               rxFull,
  output logic               txFull
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [HOST_AW-1:0] IDX_RX = HOST_AW'(HIDX_RXDATA);
  localparam logic [HOST_AW-1:0] IDX_ST = HOST_AW'(HIDX_STATUS);
  localparam logic [HOST_AW-1:0] IDX_TX = HOST_AW'(HIDX_TXDATA);

  logic hostRxWr, hostTxRd, coreDataRd, coreDataWr;

  always_comb begin
    hostRxWr   = hostWr && (hostAddr == IDX_RX);
    hostTxRd   = hostRd && (hostAddr == IDX_TX);
    coreDataRd = coreRd && (coreAddr == CADDR_DATA);
    coreDataWr = coreWr && (coreAddr == CADDR_DATA);

    // Every action is qualified by the flag at the start of the cycle
    strobe.rxLoad   = hostRxWr && !rxFull;
    strobe.rxTake   = coreDataRd && rxFull;
    strobe.txLoad   = coreDataWr && !txFull;
    strobe.txTake   = hostTxRd && txFull;
    strobe.hostStat = hostRd && (hostAddr == IDX_ST);
    strobe.coreStat = coreRd && (coreAddr == CADDR_STATUS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxFull <= 1'b0;
      txFull <= 1'b0;
    end else begin
      if (strobe.rxLoad)      rxFull <= 1'b1;
      else if (strobe.rxTake) rxFull <= 1'b0;
      if (strobe.txLoad)      txFull <= 1'b1;
      else if (strobe.txTake) txFull <= 1'b0;
    end
  end

  AST_RX_FILL: assert property (@(posedge clk) disable iff (rst)
    hostRxWr && !rxFull |=> rxFull); // R3
  AST_RX_DROP_KEEP: assert property (@(posedge clk) disable iff (rst)
    hostRxWr && rxFull && !coreDataRd |=> rxFull); // R4
  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    coreDataRd && !rxFull && !hostRxWr |=> !rxFull); // R6
  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (rst)
    hostTxRd && txFull |=> !txFull); // R9
  AST_TX_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    hostTxRd && !txFull && !coreDataWr |=> !txFull); // R10
  AST_COLLIDE_FULL: assert property (@(posedge clk) disable iff (rst)
    coreDataWr && hostTxRd && txFull |=> !txFull); // R11
  AST_COLLIDE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    hostRxWr && coreDataRd && !rxFull |=> rxFull); // R11
endmodule

// File: rtl/dbgMbxData.sv
module dbgMbxData
  import dbgMbxPkg::*;
#(
  parameter int DATA_W = dbgMbxPkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mbxStrobe_t        strobe,
  input  logic              rxFull,
  input  logic              txFull,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] coreRdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [DATA_W-1:0] STAT_MASK =
    (DATA_W'(1) << RX_FULL_BIT) | (DATA_W'(1) << TX_FULL_BIT);

  logic [DATA_W-1:0] rxWord, txWord, statusWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxWord <= '0;
      txWord <= '0;
    end else begin
      if (strobe.rxLoad) rxWord <= hostWdata;
      if (strobe.txLoad) txWord <= coreWdata;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[RX_FULL_BIT] = rxFull;
    statusWord[TX_FULL_BIT] = txFull;

    hostRdata = '0;
    if (strobe.hostStat)    hostRdata = statusWord;
    else if (strobe.txTake) hostRdata = txWord;

    coreRdata = '0;
    if (strobe.coreStat)    coreRdata = statusWord;
    else if (strobe.rxTake) coreRdata = rxWord;
  end

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strobe.rxLoad |=> rxWord == $past(hostWdata)); // R3
  AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strobe.txLoad |=> txWord == $past(coreWdata)); // R7
  AST_TX_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
    txFull && !strobe.txTake |=> $stable(txWord)); // R8
  AST_STAT_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.hostStat |-> (hostRdata & ~STAT_MASK) == '0); // R2
endmodule

// File: rtl/dbgMailbox.sv
module dbgMailbox
  import dbgMbxPkg::*;
#(
  parameter int DATA_W  = dbgMbxPkg::DATA_W,
  parameter int HOST_AW = dbgMbxPkg::HOST_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  input  logic               coreAddr,
  input  logic               coreRd,
  input  logic               coreWr,
  input  logic [DATA_W-1:0]  coreWdata,
  output logic [DATA_W-1:0]  coreRdata
);
  timeunit 1ns;
  timeprecision 1ps;

  mbxStrobe_t strobe;
  logic       rxFull, txFull;

  dbgMbxCtrl #(.HOST_AW(HOST_AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .coreAddr(coreAddr), .coreRd(coreRd), .coreWr(coreWr),
    .strobe(strobe), .rxFull(rxFull), .txFull(txFull)
  );

  dbgMbxData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rxFull(rxFull), .txFull(txFull),
    .hostWdata(hostWdata), .coreWdata(coreWdata),
    .hostRdata(hostRdata), .coreRdata(coreRdata)
  );
endmodule

// File: tb/dbgMailbox_bench.sv
module dbgMailbox_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  hostAddr = '0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic        coreAddr = 1'b0, coreRd = 1'b0, coreWr = 1'b0;
  logic [31:0] coreWdata = '0, coreRdata;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  bit       mRxFull = 0, mTxFull = 0;
  bit [31:0] mRxWord = 0, mTxWord = 0;

  always #10 clk = ~clk;  // 50 MHz

  dbgMailbox u_dbgMailbox (
    .clk(clk), .rst(rst),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .coreAddr(coreAddr), .coreRd(coreRd), .coreWr(coreWr),
    .coreWdata(coreWdata), .coreRdata(coreRdata)
  );

  function automatic bit [31:0] modelStatus();
    bit [31:0] s = 0;
    s[30] = mRxFull;
    s[29] = mTxFull;
    return s;
  endfunction

  // Model advances on each edge from the flags held before the edge
  always @(posedge clk) begin
    bit rxW, rxR, txW, txR;
    rxW = hostWr && hostAddr == 8'd32;
    rxR = coreRd && coreAddr == 1'b1;
    txW = coreWr && coreAddr == 1'b1;
    txR = hostRd && hostAddr == 8'd35;
    if (rst) begin
      mRxFull = 0; mTxFull = 0; mRxWord = 0; mTxWord = 0;
    end else begin
      if (rxW && !mRxFull) begin mRxFull = 1; mRxWord = hostWdata; end
      else if (rxR && mRxFull) mRxFull = 0;
      if (txW && !mTxFull) begin mTxFull = 1; mTxWord = coreWdata; end
      else if (txR && mTxFull) mTxFull = 0;
    end
  end

  task automatic compare(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check mid low phase
  task automatic cyc(input string tag,
                     input bit [7:0] hA, input bit hR, input bit hW, input bit [31:0] hD,
                     input bit cA, input bit cR, input bit cW, input bit [31:0] cD);
    bit [31:0] eh, ec;
    @(negedge clk);
    hostAddr = hA; hostRd = hR; hostWr = hW; hostWdata = hD;
    coreAddr = cA; coreRd = cR; coreWr = cW; coreWdata = cD;
    #5;
    eh = 0; ec = 0;
    if (hR && hA == 8'd34) eh = modelStatus();
    else if (hR && hA == 8'd35 && mTxFull) eh = mTxWord;
    if (cR && cA == 1'b0) ec = modelStatus();
    else if (cR && cA == 1'b1 && mRxFull) ec = mRxWord;
    compare({tag, " host"}, hostRdata, eh);
    compare({tag, " core"}, coreRdata, ec);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 8'd0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic statBoth(input string tag, input bit [31:0] exp);
    cyc(tag, 8'd34, 1, 0, 0, 1'b0, 1, 0, 0);
    compare({tag, " host status"}, hostRdata, exp);
    compare({tag, " core status"}, coreRdata, exp);
  endtask

  initial begin
    repeat (2) idle("R1 in reset");
    @(negedge clk); rst = 0;
    statBoth("R1 reset state", 32'h0);

    cyc("R3 host fill rx", 8'd32, 0, 1, 32'hA5A5_0001, 0, 0, 0, 0);
    statBoth("R2 R3 rx full bit30", 32'h4000_0000);
    cyc("R4 write while full", 8'd32, 0, 1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    statBoth("R4 flag kept", 32'h4000_0000);
    cyc("R5 R4 core take", 8'd0, 0, 0, 0, 1'b1, 1, 0, 0);
    compare("R5 R4 word kept", coreRdata, 32'hA5A5_0001);
    cyc("R5 R6 back-to-back", 8'd0, 0, 0, 0, 1'b1, 1, 0, 0);
    compare("R6 empty read zero", coreRdata, 32'h0);
    statBoth("R5 rx cleared", 32'h0);

    cyc("R7 core fill tx", 8'd0, 0, 0, 0, 1'b1, 0, 1, 32'h1234_5678);
    statBoth("R2 R7 tx full bit29", 32'h2000_0000);
    cyc("R8 write while full", 8'd0, 0, 0, 0, 1'b1, 0, 1, 32'h9999_9999);
    cyc("R9 R8 host take", 8'd35, 1, 0, 0, 0, 0, 0, 0);
    compare("R9 R8 word kept", hostRdata, 32'h1234_5678);
    cyc("R10 empty host read", 8'd35, 1, 0, 0, 0, 0, 0, 0);
    compare("R10 zero", hostRdata, 32'h0);
    statBoth("R10 flag unchanged", 32'h0);

    // Collisions
    cyc("R11 rx empty collide", 8'd32, 0, 1, 32'h0BAD_F00D, 1'b1, 1, 0, 0);
    compare("R11 rx empty read zero", coreRdata, 32'h0);
    statBoth("R11 rx set wins", 32'h4000_0000);
    cyc("R11 rx full collide", 8'd32, 0, 1, 32'h7777_7777, 1'b1, 1, 0, 0);
    compare("R11 rx old word", coreRdata, 32'h0BAD_F00D);
    statBoth("R11 rx cleared", 32'h0);
    cyc("R11 tx empty collide", 8'd35, 1, 0, 0, 1'b1, 0, 1, 32'hCAFE_0001);
    compare("R11 tx empty read zero", hostRdata, 32'h0);
    statBoth("R11 tx set wins", 32'h2000_0000);
    cyc("R11 tx full collide", 8'd35, 1, 0, 0, 1'b1, 0, 1, 32'h5555_5555);
    compare("R11 tx old word", hostRdata, 32'hCAFE_0001);
    statBoth("R11 tx cleared", 32'h0);

    // Other indices
    cyc("R12 write idx33", 8'd33, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R12 write idx34", 8'd34, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R12 read idx32", 8'd32, 1, 0, 0, 0, 0, 0, 0);
    compare("R12 read idx32 zero", hostRdata, 32'h0);
    cyc("R12 read idx160", 8'd160, 1, 0, 0, 0, 0, 0, 0);
    compare("R12 read idx160 zero", hostRdata, 32'h0);
    statBoth("R12 nothing changed", 32'h0);

    // Reset while both mailboxes are full
    cyc("R3 refill rx", 8'd32, 0, 1, 32'h1, 1'b1, 0, 1, 32'h2);
    statBoth("R2 both full", 32'h6000_0000);
    @(negedge clk); rst = 1;
    idle("R1 reset pulse");
    @(negedge clk); rst = 0;
    statBoth("R1 flags cleared", 32'h0);

    // Random traffic judged by the model
    for (int i = 0; i < 400; i++) begin
      bit [7:0] ha;
      int sel = $urandom_range(0, 3);
      ha = (sel == 0) ? 8'd32 : (sel == 1) ? 8'd34 : (sel == 2) ? 8'd35 : 8'd36;
      cyc("R11 random", ha, 1'($urandom), 1'($urandom), $urandom,
          1'($urandom), 1'($urandom), 1'($urandom), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule